// File: doc/BRIEF.md
# In-Order Retirement Buffer with Precise Faults

This block is a circular reorder buffer for a speculative out-of-order core. When an instruction issues, the buffer gives it the next slot in program order and returns the slot index as its tag. Execution units then return results by tag in any order. Each result can carry a fault flag (an exception) or a wrong-path flag (a branch that was mispredicted). The buffer keeps every result from the moment it completes until the moment it retires. It retires slots one at a time from the oldest end, and each retirement writes the result to the architectural register file port.

Faults and wrong-path flags are not acted on when the result arrives. They take effect only when the flagged slot becomes the oldest. At that point no register write happens. Instead the block emits a one-cycle flush pulse, empties every slot and returns both pointers to zero. Because of this, no younger speculative result ever reaches architectural state, and every fault is taken at a precise point.

Issue is accepted only when a slot is free and the caller also reports a free reservation station in the same cycle.

Top module: `rob_top`

## Requirements
- R1: The tag returned with an accepted allocation is the index of the newest slot. Tags start at 0 after reset or flush and count upward by one per accepted allocation, wrapping from DEPTH-1 to 0.
- R2: `alloc_ok` is 1 exactly when `alloc_req` and `rs_free` are both 1, fewer than DEPTH slots are occupied, and no flush is being raised in that cycle.
- R3: A retirement happens in the same cycle, combinationally, whenever the oldest slot holds a written result with no fault or wrong-path flag. It shows as `rf_we`=1, with `rf_addr` equal to the slot's destination register and `rf_data` equal to its result. Otherwise `rf_we`=0.
- R4: Results written out of order still retire strictly in allocation order, at most one per cycle. A slot whose result has not arrived blocks every younger slot.
- R5: When the oldest slot carries the fault flag and its result is written, `flush`=1 and `flush_exc`=1 for one cycle and `rf_we`=0. In the next cycle the buffer is empty and the next tag is 0.
- R6: When the oldest written slot carries only the wrong-path flag, `flush`=1 with `flush_exc`=0. Results of younger slots are never written to the register file.
- R7: A writeback to a slot that is not occupied is ignored. That slot does not retire until a writeback arrives after it has been allocated.
- R8: One allocation, one writeback and one retirement may all take place in the same cycle.
- R9: During reset the buffer is empty, with `rf_we`=0 and `flush`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request to allocate a slot for an issuing instruction |
| rs_free | input | 1 | A reservation station is available this cycle |
| alloc_dest | input | REG_W | Destination register of the issuing instruction |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | TAG_W | Slot index given to the issuing instruction |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | TAG_W | Slot addressed by the writeback |
| wb_data | input | DATA_W | Result value |
| wb_exc | input | 1 | Result raised an exception |
| wb_mispred | input | 1 | Result is a mispredicted branch |
| rf_we | output | 1 | Architectural register write enable (retirement) |
| rf_addr | output | REG_W | Architectural register number |
| rf_data | output | DATA_W | Value written to the register |
| flush | output | 1 | One-cycle flush pulse on a faulted oldest slot |
| flush_exc | output | 1 | Flush cause: 1 for exception, 0 for misprediction |

## Verification
The bench builds the buffer with DEPTH=8, 32-bit results and 5-bit register numbers. At this depth the full condition and the wrap of the tag from 7 back to 0 are reached after only a handful of allocations. The small register field still allows distinct destination numbers in every scenario, so a retirement taken in the wrong order shows up directly on `rf_addr`.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Per-slot state flags
    typedef struct packed {
        logic valid;    // slot occupied
        logic done;     // result written
        logic exc;      // exception recorded
        logic mispred;  // branch mispredicted
    } rob_flags_t;

    typedef enum logic {
        CAUSE_MISPRED = 1'b0,
        CAUSE_EXC     = 1'b1
    } flush_cause_e;

    // Circular increment for a buffer whose depth need not be a power of two
    function automatic int wrap_inc(input int idx, input int depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

    function automatic logic slot_faulted(input rob_flags_t f);
        return f.exc | f.mispred;
    endfunction

    function automatic logic slot_ready(input rob_flags_t f);
        return f.valid & f.done;
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    import rob_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= PTR_W'(wrap_inc(int'(tail), DEPTH));
            if (pop)  head <= PTR_W'(wrap_inc(int'(head), DEPTH));
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign full = (count == CNT_W'(DEPTH));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (count == $past(count) || count == $past(count) + CNT_W'(1)
                    || count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/rob_slot_store.sv
module rob_slot_store #(
    parameter int DEPTH  = 8,
    parameter int PTR_W  = 3,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               alloc_en,
    input  logic [PTR_W-1:0]   alloc_idx,
    input  logic [REG_W-1:0]   alloc_dest,
    input  logic               wb_en,
    input  logic [PTR_W-1:0]   wb_idx,
    input  logic [DATA_W-1:0]  wb_data,
    input  logic               wb_exc,
    input  logic               wb_mispred,
    input  logic               retire_en,
    input  logic [PTR_W-1:0]   head_idx,
    output rob_pkg::rob_flags_t head_flags,
    output logic [REG_W-1:0]   head_dest,
    output logic [DATA_W-1:0]  head_data
);
    import rob_pkg::*;

    rob_flags_t        flags_q [DEPTH];
    logic [REG_W-1:0]  dest_q  [DEPTH];
    logic [DATA_W-1:0] data_q  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic alloc_hit;
        logic wb_hit;
        logic retire_hit;

        assign alloc_hit  = alloc_en  && (alloc_idx == PTR_W'(i));
        assign wb_hit     = wb_en     && (wb_idx    == PTR_W'(i));
        assign retire_hit = retire_en && (head_idx  == PTR_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                flags_q[i] <= '0;
            end else if (alloc_hit) begin
                flags_q[i] <= '{valid: 1'b1, done: 1'b0, exc: 1'b0, mispred: 1'b0};
                dest_q[i]  <= alloc_dest;
            end else begin
                if (wb_hit && flags_q[i].valid) begin
                    flags_q[i].done    <= 1'b1;
                    flags_q[i].exc     <= wb_exc;
                    flags_q[i].mispred <= wb_mispred;
                    data_q[i]          <= wb_data;
                end
                if (retire_hit) begin
                    flags_q[i].valid <= 1'b0;
                end
            end
        end

        p_wb_ignored_r7: assert property (@(posedge clk) disable iff (rst)
            (wb_hit && !flags_q[i].valid) |=> !flags_q[i].done);
    end

    assign head_flags = flags_q[head_idx];
    assign head_dest  = dest_q[head_idx];
    assign head_data  = data_q[head_idx];

    p_alloc_slot_free_r2: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !flags_q[alloc_idx].valid);

endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  rob_pkg::rob_flags_t   head_flags,
    input  logic [REG_W-1:0]      head_dest,
    input  logic [DATA_W-1:0]     head_data,
    output logic                  rf_we,
    output logic [REG_W-1:0]      rf_addr,
    output logic [DATA_W-1:0]     rf_data,
    output logic                  flush,
    output rob_pkg::flush_cause_e flush_cause,
    output logic                  pop
);
    import rob_pkg::*;

    logic ready;
    logic faulted;

    always_comb begin
        ready       = slot_ready(head_flags);
        faulted     = slot_faulted(head_flags);
        rf_we       = ready && !faulted;
        flush       = ready && faulted;
        pop         = rf_we;
        rf_addr     = head_dest;
        rf_data     = head_data;
        flush_cause = head_flags.exc ? CAUSE_EXC : CAUSE_MISPRED;
    end

endmodule

// File: rtl/rob_top.sv
module rob_top #(
    parameter  int DEPTH  = 8,
    parameter  int REG_W  = 5,
    parameter  int DATA_W = 32,
    localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    input  logic              rs_free,
    input  logic [REG_W-1:0]  alloc_dest,
    output logic              alloc_ok,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_addr,
    output logic [DATA_W-1:0] rf_data,
    output logic              flush,
    output logic              flush_exc
);
    import rob_pkg::*;

    logic [TAG_W-1:0]  head;
    logic [TAG_W-1:0]  tail;
    logic [CNT_W-1:0]  count;
    logic              full;
    logic              pop;
    rob_flags_t        head_flags;
    logic [REG_W-1:0]  head_dest;
    logic [DATA_W-1:0] head_data;
    flush_cause_e      cause;

    assign alloc_ok  = alloc_req && rs_free && !full && !flush;
    assign alloc_tag = tail;
    assign flush_exc = flush && (cause == CAUSE_EXC);

    rob_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(TAG_W), .CNT_W(CNT_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .push  (alloc_ok),
        .pop   (pop),
        .clear (flush),
        .head  (head),
        .tail  (tail),
        .count (count),
        .full  (full)
    );

    rob_slot_store #(.DEPTH(DEPTH), .PTR_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clear      (flush),
        .alloc_en   (alloc_ok),
        .alloc_idx  (tail),
        .alloc_dest (alloc_dest),
        .wb_en      (wb_valid),
        .wb_idx     (wb_tag),
        .wb_data    (wb_data),
        .wb_exc     (wb_exc),
        .wb_mispred (wb_mispred),
        .retire_en  (pop),
        .head_idx   (head),
        .head_flags (head_flags),
        .head_dest  (head_dest),
        .head_data  (head_data)
    );

    rob_retire #(.REG_W(REG_W), .DATA_W(DATA_W)) u_retire (
        .head_flags  (head_flags),
        .head_dest   (head_dest),
        .head_data   (head_data),
        .rf_we       (rf_we),
        .rf_addr     (rf_addr),
        .rf_data     (rf_data),
        .flush       (flush),
        .flush_cause (cause),
        .pop         (pop)
    );

    p_flush_empties_r5: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && tail == '0 && !rf_we && !flush));

    p_retire_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        (rf_we || flush) |-> (count != '0));

endmodule

// File: tb/tb_rob_top.sv
`timescale 1ns/1ps
module tb_rob_top;
    localparam int DEPTH  = 8;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              alloc_req, rs_free;
    logic [REG_W-1:0]  alloc_dest;
    logic              alloc_ok;
    logic [TAG_W-1:0]  alloc_tag;
    logic              wb_valid;
    logic [TAG_W-1:0]  wb_tag;
    logic [DATA_W-1:0] wb_data;
    logic              wb_exc, wb_mispred;
    logic              rf_we;
    logic [REG_W-1:0]  rf_addr;
    logic [DATA_W-1:0] rf_data;
    logic              flush, flush_exc;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    rob_top #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .rs_free(rs_free), .alloc_dest(alloc_dest),
        .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .wb_exc(wb_exc), .wb_mispred(wb_mispred),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .flush(flush), .flush_exc(flush_exc)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Start of a cycle: inputs idle, driven at the falling edge
    task automatic cyc();
        @(negedge clk);
        alloc_req = 0; rs_free = 1; alloc_dest = '0;
        wb_valid = 0; wb_tag = '0; wb_data = '0; wb_exc = 0; wb_mispred = 0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        cyc(); rst = 1;
        cyc(); rst = 1;
        cyc(); rst = 0;
    endtask

    task automatic req_alloc(input int dest);
        alloc_req = 1; alloc_dest = REG_W'(dest);
    endtask

    task automatic req_wb(input int tag, input int data, input logic e, input logic m);
        wb_valid = 1; wb_tag = TAG_W'(tag); wb_data = DATA_W'(data); wb_exc = e; wb_mispred = m;
    endtask

    task automatic expect_alloc(input string req, input int tag);
        chk(req, "alloc_ok", alloc_ok, 1);
        chk(req, "alloc_tag", alloc_tag, tag);
    endtask

    task automatic expect_commit(input string req, input int addr, input int data);
        chk(req, "rf_we", rf_we, 1);
        chk(req, "rf_addr", rf_addr, addr);
        chk(req, "rf_data", rf_data, longint'(unsigned'(DATA_W'(data))));
        chk(req, "flush", flush, 0);
    endtask

    task automatic expect_quiet(input string req);
        chk(req, "rf_we", rf_we, 0);
        chk(req, "flush", flush, 0);
    endtask

    task automatic t_reset();
        cyc(); rst = 1; settle();
        cyc(); rst = 1; settle();
        expect_quiet("R9");
        cyc(); rst = 0; settle();
        expect_quiet("R9");
        chk("R2", "alloc_ok idle", alloc_ok, 0);
        req_alloc(1); settle();
        expect_alloc("R1", 0);
        alloc_req = 0;
    endtask

    task automatic t_out_of_order();
        do_reset();
        cyc(); req_alloc(1); settle(); expect_alloc("R1", 0);
        cyc(); req_alloc(2); settle(); expect_alloc("R1", 1);
        cyc(); req_alloc(3); settle(); expect_alloc("R1", 2);
        cyc(); req_wb(2, 'hA2, 0, 0); settle(); expect_quiet("R4");
        cyc(); req_wb(1, 'hA1, 0, 0); settle(); expect_quiet("R4");
        cyc(); req_wb(0, 'hA0, 0, 0); settle(); expect_quiet("R4");
        cyc(); settle(); expect_commit("R4", 1, 'hA0);
        cyc(); settle(); expect_commit("R4", 2, 'hA1);
        cyc(); settle(); expect_commit("R3", 3, 'hA2);
        cyc(); settle(); expect_quiet("R3");
    endtask

    task automatic t_full_stall();
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            cyc(); req_alloc(k + 1); settle(); expect_alloc("R1", k);
        end
        cyc(); req_alloc(20); settle(); chk("R2", "alloc_ok when full", alloc_ok, 0);
        cyc(); req_wb(0, 'h55, 0, 0); settle(); chk("R2", "alloc_ok when full", alloc_ok, 0);
        cyc(); settle(); expect_commit("R3", 1, 'h55);
        cyc(); req_alloc(21); rs_free = 0; settle();
        chk("R2", "alloc_ok without station", alloc_ok, 0);
        cyc(); req_alloc(21); settle(); expect_alloc("R1", 0);
    endtask

    task automatic t_fault(input logic is_exc);
        string rq = is_exc ? "R5" : "R6";
        do_reset();
        cyc(); req_alloc(4); settle(); expect_alloc("R1", 0);
        cyc(); req_alloc(5); settle(); expect_alloc("R1", 1);
        cyc(); req_alloc(6); settle(); expect_alloc("R1", 2);
        cyc(); req_wb(2, 'hC2, 0, 0); settle();
        cyc(); req_wb(1, 'hC1, is_exc, !is_exc); settle();
        cyc(); req_wb(0, 'hC0, 0, 0); settle(); expect_quiet(rq);
        cyc(); settle(); expect_commit(rq, 4, 'hC0);
        cyc(); req_alloc(9); settle();
        chk(rq, "flush", flush, 1);
        chk(rq, "flush_exc", flush_exc, is_exc);
        chk(rq, "rf_we on faulted slot", rf_we, 0);
        chk("R2", "alloc_ok during flush", alloc_ok, 0);
        cyc(); settle();
        expect_quiet(rq);
        req_alloc(9); settle(); expect_alloc("R5", 0);
        cyc(); settle(); expect_quiet("R6");
        cyc(); settle(); expect_quiet("R6");
    endtask

    task automatic t_invalid_wb_and_overlap();
        do_reset();
        cyc(); req_alloc(7); settle(); expect_alloc("R1", 0);
        cyc(); req_wb(3, 'hEE, 0, 0); settle(); expect_quiet("R7");
        cyc(); req_wb(0, 'hD0, 0, 0); req_alloc(8); settle(); expect_alloc("R8", 1);
        cyc(); req_alloc(9); settle(); expect_alloc("R8", 2); expect_commit("R8", 7, 'hD0);
        cyc(); req_alloc(10); req_wb(1, 'hD1, 0, 0); settle(); expect_alloc("R8", 3);
        cyc(); req_alloc(11); req_wb(2, 'hD2, 0, 0); settle();
        expect_alloc("R8", 4); expect_commit("R8", 8, 'hD1);
        cyc(); settle(); expect_commit("R4", 9, 'hD2);
        cyc(); settle(); expect_quiet("R7");
        cyc(); req_wb(3, 'hD3, 0, 0); settle(); expect_quiet("R7");
        cyc(); settle(); expect_commit("R7", 10, 'hD3);
        cyc(); req_wb(4, 'hD4, 0, 0); settle(); expect_quiet("R4");
        cyc(); settle(); expect_commit("R4", 11, 'hD4);
        cyc(); settle(); expect_quiet("R4");
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1;
        alloc_req = 0; rs_free = 1; alloc_dest = '0;
        wb_valid = 0; wb_tag = '0; wb_data = '0; wb_exc = 0; wb_mispred = 0;
        t_reset();
        t_out_of_order();
        t_full_stall();
        t_fault(1'b1);
        t_fault(1'b0);
        t_invalid_wb_and_overlap();
        cyc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule